// File: doc/BRIEF.md
# Interrupt Pin Redirection and Delivery

This block sits between a bank of interrupt input lines and the interrupt fabric of a processor cluster. Every input event carries an input number and a level. The block maps the number onto one of its pins, records the request in a per-pin pending register, and turns each deliverable pin into a two-word interrupt message: a 32-bit address and a 32-bit data word. Both words are built from that pin's 64-bit redirection entry. The entry array lives in a separate register block and reaches this block as a flat input bus.

Edge pins fire once per request. Level pins track their input line. After a level pin is serviced, a per-pin in-service flag blocks any further message from it. An end-of-interrupt unit outside this block releases the flag by pulsing a clear line. Pins in external-interrupt delivery mode take their vector from a legacy controller and acknowledge it when the message is built. Messages leave one per cycle through a valid/ready port. A rotating scan pointer sets the order in which pins are served.

Top module: `irq_route_dispatch`

## Requirements
- R1: An event on input 0 acts on pin 2. Any other input number N below the pin count acts on pin N.
- R2: An event whose input number is at or above the pin count changes no pin and causes no message.
- R3: On a level pin (entry bit 15 = 1), a high event sets the pin's pending bit and a low event clears it. A pending bit cleared this way never produces a message.
- R4: On an edge pin (entry bit 15 = 0), a high event is discarded if the mask bit (entry bit 16) is set. Unmasking the pin later produces no message for that event.
- R5: A pending pin whose mask bit is set is skipped and keeps its pending bit. Once the pin is unmasked, its message is sent.
- R6: Loading an edge pin's message clears its pending bit, so one high event gives one message. A new high event that arrives in the same cycle as that load is kept and gives a second message.
- R7: Loading a level pin's message sets its in-service flag (output `rirr_q`). While the flag is set, the pin sends nothing more. Pulsing `rirr_clr` for a pin that is still pending lets it send again.
- R8: Message address = 0xFEE00000 OR (destination, entry bits 63:48, shifted left by 12) OR (destination-mode bit, entry bit 11, shifted left by 2).
- R9: Message data = vector in bits 7:0, delivery mode (entry bits 10:8) in bits 10:8, and trigger mode in bit 15. The vector is entry bits 7:0, except in delivery mode 3'b111, where it is `legacy_vec` and `legacy_ack` pulses once.
- R10: Pins are served in ascending order, starting at the pin after the last one loaded and wrapping past the highest pin.
- R11: While `msg_valid` is high and `msg_ready` is low, the message and its pin number stay unchanged.
- R12: A pin whose entry is edge-triggered has its in-service flag cleared by the next cycle.
- R13: After reset, no message is valid, and no pin is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An input event is present this cycle |
| req_src | input | SRC_W (5) | Input number of the event |
| req_level | input | 1 | Level carried by the event |
| rte_flat | input | NUM_PINS*64 | Redirection entries, pin i at bits i*64+63 : i*64 |
| legacy_vec | input | 8 | Vector offered by the legacy controller |
| legacy_ack | output | 1 | Legacy vector consumed this cycle |
| rirr_clr | input | NUM_PINS | Per-pin clear of the in-service flag |
| rirr_q | output | NUM_PINS | Per-pin in-service flag |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |
| msg_pin | output | PIN_W (5) | Pin that produced the message |

## Verification
The sharpest collision is a new high event on an edge pin arriving in the same cycle as the load that clears that pin's pending bit. The bench provokes it by issuing two back-to-back events on one pin while the output port is free. It then counts exactly two messages; a design where the clear wins would show only one. The second overlap is a stalled output port meeting several pins that become deliverable together. The bench unmasks three pending pins at once while holding ready low. It then checks that the held message stays unchanged, and that the remaining pins follow in order from the rotating pointer, including the wrap past the top pin.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int RTE_W        = 64;
   localparam int F_VEC_LSB    = 0;
   localparam int F_VEC_W      = 8;
   localparam int F_DLV_LSB    = 8;
   localparam int F_DLV_W      = 3;
   localparam int F_DSTMODE    = 11;
   localparam int F_TRIG       = 15;
   localparam int F_MASK       = 16;
   localparam int F_DEST_LSB   = 48;
   localparam int F_DEST_W     = 16;

   localparam logic [F_DLV_W-1:0] DLV_LEGACY = 3'b111;

   localparam logic [31:0] MSG_BASE    = 32'hFEE0_0000;
   localparam int          A_DEST_SH   = 12;
   localparam int          A_DMODE_SH  = 2;
   localparam int          D_VEC_SH    = 0;
   localparam int          D_DLV_SH    = 8;
   localparam int          D_TRIG_SH   = 15;

   typedef struct packed {
      logic [F_VEC_W-1:0]  vec;
      logic [F_DLV_W-1:0]  dlv;
      logic                dst_logical;
      logic                trig_lvl;
      logic                masked;
      logic [F_DEST_W-1:0] dest;
   } rte_t;

   function automatic rte_t rte_decode(input logic [RTE_W-1:0] e);
      rte_t r;
      r.vec         = e[F_VEC_LSB +: F_VEC_W];
      r.dlv         = e[F_DLV_LSB +: F_DLV_W];
      r.dst_logical = e[F_DSTMODE];
      r.trig_lvl    = e[F_TRIG];
      r.masked      = e[F_MASK];
      r.dest        = e[F_DEST_LSB +: F_DEST_W];
      return r;
   endfunction

   function automatic logic [31:0] msg_addr_of(input rte_t r);
      return MSG_BASE
           | (32'(r.dest) << A_DEST_SH)
           | (32'(r.dst_logical) << A_DMODE_SH);
   endfunction

   function automatic logic [31:0] msg_data_of(input rte_t r, input logic [F_VEC_W-1:0] v);
      return (32'(v) << D_VEC_SH)
           | (32'(r.dlv) << D_DLV_SH)
           | (32'(r.trig_lvl) << D_TRIG_SH);
   endfunction

endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
   parameter int NUM_PINS  = 24,
   parameter int SRC_W     = 5,
   parameter int PIN_W     = 5,
   parameter int REMAP_SRC = 0,
   parameter int REMAP_DST = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [SRC_W-1:0]    req_src,
   input  logic                req_level,
   input  logic [NUM_PINS-1:0] lvl_vec,
   input  logic [NUM_PINS-1:0] mask_vec,
   input  logic                svc_fire,
   input  logic [PIN_W-1:0]    svc_pin,
   input  logic [NUM_PINS-1:0] rirr_clr,
   output logic [NUM_PINS-1:0] pend_q,
   output logic [NUM_PINS-1:0] rirr_q,
   output logic [NUM_PINS-1:0] elig
);

   localparam logic [SRC_W-1:0] SRC_FROM = SRC_W'(REMAP_SRC);
   localparam logic [SRC_W-1:0] SRC_TO   = SRC_W'(REMAP_DST);

   logic [SRC_W-1:0]    mapped;
   logic                in_range;
   logic [NUM_PINS-1:0] pend_d;
   logic [NUM_PINS-1:0] rirr_d;

   // R1: one input number is steered onto another pin
   assign mapped   = (req_src == SRC_FROM) ? SRC_TO : req_src;
   // R2: numbers at or beyond the pin count reach nothing
   assign in_range = ({{(32-SRC_W){1'b0}}, mapped} < 32'(NUM_PINS));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hit, set_req, lvl_drop, svc_here, svc_edge, svc_lvl;

      assign hit      = req_valid && in_range && (mapped == SRC_W'(i));
      // R3/R4: level pins always latch a high, edge pins only when unmasked
      assign set_req  = hit && req_level && (lvl_vec[i] || !mask_vec[i]);
      assign lvl_drop = hit && !req_level && lvl_vec[i];
      assign svc_here = svc_fire && (svc_pin == PIN_W'(i));
      assign svc_edge = svc_here && !lvl_vec[i];
      assign svc_lvl  = svc_here && lvl_vec[i];

      // R6: a new request beats the clear caused by servicing
      assign pend_d[i] = set_req ? 1'b1 :
                         (lvl_drop || svc_edge) ? 1'b0 : pend_q[i];
      // R7/R12: flag set by level service, cleared by pulse or edge mode
      assign rirr_d[i] = !lvl_vec[i] ? 1'b0 :
                         svc_lvl     ? 1'b1 :
                         rirr_clr[i] ? 1'b0 : rirr_q[i];
      // R5/R7: pending, unmasked, and not held by the in-service flag
      assign elig[i]   = pend_q[i] && !mask_vec[i] && (!lvl_vec[i] || !rirr_q[i]);

      // R4
      masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && req_level && !lvl_vec[i] && mask_vec[i] && !pend_q[i]) |=> !pend_q[i]);

      // R7
      level_coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (svc_here && lvl_vec[i]) |-> !rirr_q[i]);

      // R12
      edge_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_vec[i] && !svc_here) |=> (!rirr_q[i] || lvl_vec[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         rirr_q <= '0;
      end else begin
         pend_q <= pend_d;
         rirr_q <= rirr_d;
      end
   end

endmodule

// File: rtl/irq_scan_pick.sv
module irq_scan_pick #(
   parameter int NUM_PINS = 24,
   parameter int PIN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] elig,
   input  logic                advance,
   input  logic [PIN_W-1:0]    adv_pin,
   output logic                pick_valid,
   output logic [PIN_W-1:0]    pick_pin
);

   localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

   logic [PIN_W-1:0] ptr_q;

   // R10: first eligible pin at or after the pointer, wrapping at the top
   always_comb begin
      pick_valid = 1'b0;
      pick_pin   = '0;
      for (int k = NUM_PINS - 1; k >= 0; k--) begin
         int idx;
         idx = int'(ptr_q) + k;
         if (idx >= NUM_PINS) idx = idx - NUM_PINS;
         if (elig[idx]) begin
            pick_valid = 1'b1;
            pick_pin   = PIN_W'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= (adv_pin == LAST_PIN) ? '0 : adv_pin + 1'b1;
   end

   // R10
   pick_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> elig[pick_pin]);

   // R10
   pointer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_PIN);

endmodule

// File: rtl/irq_msg_pack.sv
module irq_msg_pack
   import irq_route_pkg::*;
#(
   parameter int PIN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pick_valid,
   input  logic [PIN_W-1:0] pick_pin,
   input  rte_t             sel_rte,
   input  logic [7:0]       legacy_vec,
   input  logic             msg_ready,
   output logic             load,
   output logic             legacy_ack,
   output logic             msg_valid,
   output logic [31:0]      msg_addr,
   output logic [31:0]      msg_data,
   output logic [PIN_W-1:0] msg_pin
);

   logic       use_legacy;
   logic [7:0] vec_sel;

   // R11: load only into an empty or draining slot
   assign load       = pick_valid && (!msg_valid || msg_ready);
   // R9: legacy vector source in external-interrupt mode
   assign use_legacy = (sel_rte.dlv == DLV_LEGACY);
   assign vec_sel    = use_legacy ? legacy_vec : sel_rte.vec;
   assign legacy_ack = load && use_legacy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
         msg_pin   <= '0;
      end else if (load) begin
         msg_valid <= 1'b1;
         msg_addr  <= msg_addr_of(sel_rte);
         msg_data  <= msg_data_of(sel_rte, vec_sel);
         msg_pin   <= pick_pin;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                     && $stable(msg_data) && $stable(msg_pin)));

   // R9
   legacy_ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_ack |=> msg_valid);

endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
   import irq_route_pkg::*;
#(
   parameter int NUM_PINS  = 24,
   parameter int SRC_W     = $clog2(NUM_PINS),
   parameter int REMAP_SRC = 0,
   parameter int REMAP_DST = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [SRC_W-1:0]            req_src,
   input  logic                        req_level,
   input  logic [NUM_PINS*RTE_W-1:0]   rte_flat,
   input  logic [7:0]                  legacy_vec,
   output logic                        legacy_ack,
   input  logic [NUM_PINS-1:0]         rirr_clr,
   output logic [NUM_PINS-1:0]         rirr_q,
   output logic                        msg_valid,
   input  logic                        msg_ready,
   output logic [31:0]                 msg_addr,
   output logic [31:0]                 msg_data,
   output logic [$clog2(NUM_PINS)-1:0] msg_pin
);

   localparam int PIN_W = $clog2(NUM_PINS);

   if (NUM_PINS < 3 || NUM_PINS > 64) begin : g_bad_pins
      $error("irq_route_dispatch: NUM_PINS out of supported range");
   end
   if (SRC_W < PIN_W || SRC_W > 16) begin : g_bad_src
      $error("irq_route_dispatch: SRC_W cannot address every pin");
   end
   if (REMAP_DST >= NUM_PINS) begin : g_bad_remap
      $error("irq_route_dispatch: remap target beyond pin count");
   end

   rte_t                rte_arr [NUM_PINS];
   logic [NUM_PINS-1:0] lvl_vec;
   logic [NUM_PINS-1:0] mask_vec;
   logic [NUM_PINS-1:0] pend_q;
   logic [NUM_PINS-1:0] elig;
   logic                pick_valid;
   logic [PIN_W-1:0]    pick_pin;
   logic                load;
   rte_t                sel_rte;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
      logic [RTE_W-1:0] ent;
      logic             unused_rte_bits;
      assign ent             = rte_flat[i*RTE_W +: RTE_W];
      assign rte_arr[i]      = rte_decode(ent);
      assign lvl_vec[i]      = rte_arr[i].trig_lvl;
      assign mask_vec[i]     = rte_arr[i].masked;
      assign unused_rte_bits = ^{ent[14:12], ent[47:17]};
   end

   assign sel_rte = rte_arr[pick_pin];

   irq_pend_ctrl #(
      .NUM_PINS  (NUM_PINS),
      .SRC_W     (SRC_W),
      .PIN_W     (PIN_W),
      .REMAP_SRC (REMAP_SRC),
      .REMAP_DST (REMAP_DST)
   ) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_src   (req_src),
      .req_level (req_level),
      .lvl_vec   (lvl_vec),
      .mask_vec  (mask_vec),
      .svc_fire  (load),
      .svc_pin   (pick_pin),
      .rirr_clr  (rirr_clr),
      .pend_q    (pend_q),
      .rirr_q    (rirr_q),
      .elig      (elig)
   );

   irq_scan_pick #(
      .NUM_PINS (NUM_PINS),
      .PIN_W    (PIN_W)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .elig       (elig),
      .advance    (load),
      .adv_pin    (pick_pin),
      .pick_valid (pick_valid),
      .pick_pin   (pick_pin)
   );

   irq_msg_pack #(
      .PIN_W (PIN_W)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick_valid (pick_valid),
      .pick_pin   (pick_pin),
      .sel_rte    (sel_rte),
      .legacy_vec (legacy_vec),
      .msg_ready  (msg_ready),
      .load       (load),
      .legacy_ack (legacy_ack),
      .msg_valid  (msg_valid),
      .msg_addr   (msg_addr),
      .msg_data   (msg_data),
      .msg_pin    (msg_pin)
   );

   // R5
   pick_pending_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> (pend_q[pick_pin] && !mask_vec[pick_pin]));

   // R13
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!msg_valid && (rirr_q == '0)));

endmodule

// File: tb/irq_route_dispatch_bench.sv
module irq_route_dispatch_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 24;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           req_valid;
   logic [4:0]     req_src;
   logic           req_level;
   logic [NP*64-1:0] rte_flat;
   logic [7:0]     legacy_vec;
   logic           legacy_ack;
   logic [NP-1:0]  rirr_clr;
   logic [NP-1:0]  rirr_q;
   logic           msg_valid;
   logic           msg_ready;
   logic [31:0]    msg_addr;
   logic [31:0]    msg_data;
   logic [4:0]     msg_pin;

   logic [63:0] ent [NP];
   int n_tests = 0;
   int n_fail  = 0;
   int ack_cnt = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb
      for (int i = 0; i < NP; i++) rte_flat[i*64 +: 64] = ent[i];

   always @(negedge clk) if (legacy_ack) ack_cnt++;

   irq_route_dispatch u_irq_route_dispatch (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
      .req_level(req_level), .rte_flat(rte_flat), .legacy_vec(legacy_vec),
      .legacy_ack(legacy_ack), .rirr_clr(rirr_clr), .rirr_q(rirr_q),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
      .msg_data(msg_data), .msg_pin(msg_pin)
   );

   function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
                                      input logic lg, input logic trig,
                                      input logic msk, input logic [15:0] dest);
      logic [63:0] e = '0;
      e[7:0] = vec; e[10:8] = dlv; e[11] = lg; e[15] = trig; e[16] = msk;
      e[63:48] = dest;
      return e;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_req(input logic [4:0] src, input logic lvl);
      req_valid = 1'b1; req_src = src; req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_clr(input int pin);
      rirr_clr[pin] = 1'b1;
      @(negedge clk);
      rirr_clr = '0;
   endtask

   task automatic wait_msg(input int maxc, output bit got, output logic [31:0] a,
                           output logic [31:0] d, output logic [4:0] p);
      got = 1'b0; a = '0; d = '0; p = '0;
      for (int c = 0; c < maxc && !got; c++) begin
         if (msg_valid) begin
            got = 1'b1; a = msg_addr; d = msg_data; p = msg_pin;
         end
         @(negedge clk);
      end
   endtask

   task automatic count_msgs(input int n, output int cnt);
      cnt = 0;
      for (int c = 0; c < n; c++) begin
         if (msg_valid) cnt++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check("R13 msg_valid after reset", 64'(msg_valid), 64'd0);
      check("R13 rirr after reset", 64'(rirr_q), 64'd0);
   endtask

   task automatic t_edge_basic();
      bit g; logic [31:0] a, d; logic [4:0] p;
      ent[5] = mk(8'h31, 3'd0, 1'b1, 1'b0, 1'b0, 16'h000A);
      pulse_req(5'd5, 1'b1);
      wait_msg(6, g, a, d, p);
      check("R8 edge msg addr", 64'(a), 64'hFEE0A004);
      check("R9 edge msg data", 64'(d), 64'h31);
      check("R1 identity pin", 64'(p), 64'd5);
      ent[5][16] = 1'b1;
   endtask

   task automatic t_remap();
      bit g; logic [31:0] a, d; logic [4:0] p;
      ent[2] = mk(8'h42, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
      pulse_req(5'd0, 1'b1);
      wait_msg(6, g, a, d, p);
      check("R1 input 0 lands on pin 2", 64'(p), 64'd2);
      check("R1 remapped vector", 64'(d), 64'h42);
      ent[2][16] = 1'b1;
   endtask

   task automatic t_out_of_range();
      int cnt;
      ent[3] = mk(8'h13, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      pulse_req(5'd27, 1'b1);
      count_msgs(6, cnt);
      check("R2 out-of-range input ignored", 64'(cnt), 64'd0);
      ent[3][16] = 1'b1;
   endtask

   task automatic t_masked_edge();
      int cnt;
      ent[7] = mk(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      pulse_req(5'd7, 1'b1);
      ent[7][16] = 1'b0;
      count_msgs(6, cnt);
      check("R4 masked edge request dropped", 64'(cnt), 64'd0);
      ent[7][16] = 1'b1;
   endtask

   task automatic t_level();
      bit g; logic [31:0] a, d; logic [4:0] p; int cnt;
      ent[9] = mk(8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1234);
      pulse_req(5'd9, 1'b1);
      wait_msg(6, g, a, d, p);
      check("R8 level msg addr", 64'(a), 64'hFFE34000);
      check("R9 level msg data with trigger bit", 64'(d), 64'h8055);
      check("R7 in-service flag set", 64'(rirr_q[9]), 64'd1);
      pulse_req(5'd9, 1'b1);
      count_msgs(5, cnt);
      check("R7 no resend while in service", 64'(cnt), 64'd0);
      pulse_clr(9);
      wait_msg(6, g, a, d, p);
      check("R7 resend after flag clear", 64'(g), 64'd1);
      pulse_req(5'd9, 1'b0);
      pulse_clr(9);
      count_msgs(5, cnt);
      check("R3 low level clears pending", 64'(cnt), 64'd0);
      ent[9][16] = 1'b1;
   endtask

   task automatic t_masked_level();
      bit g; logic [31:0] a, d; logic [4:0] p; int cnt;
      ent[11] = mk(8'h60, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      pulse_req(5'd11, 1'b1);
      count_msgs(5, cnt);
      check("R5 masked pending pin skipped", 64'(cnt), 64'd0);
      ent[11][16] = 1'b0;
      wait_msg(6, g, a, d, p);
      check("R5 delivered after unmask", 64'(p), 64'd11);
      pulse_req(5'd11, 1'b0);
      pulse_clr(11);
      ent[11][16] = 1'b1;
   endtask

   task automatic t_legacy();
      bit g; logic [31:0] a, d; logic [4:0] p; int a0;
      legacy_vec = 8'h99;
      ent[4] = mk(8'h00, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0);
      a0 = ack_cnt;
      pulse_req(5'd4, 1'b1);
      wait_msg(6, g, a, d, p);
      check("R9 legacy vector and mode in data", 64'(d), 64'h0799);
      check("R9 legacy ack once", 64'(ack_cnt - a0), 64'd1);
      ent[4][16] = 1'b1;
   endtask

   task automatic t_order_stall();
      bit g; logic [31:0] a, d; logic [4:0] p; bit stable = 1'b1;
      ent[3]  = mk(8'h03, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      ent[6]  = mk(8'h06, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      ent[12] = mk(8'h0C, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      pulse_req(5'd3, 1'b1);
      pulse_req(5'd6, 1'b1);
      pulse_req(5'd12, 1'b1);
      msg_ready = 1'b0;
      ent[3][16] = 1'b0; ent[6][16] = 1'b0; ent[12][16] = 1'b0;
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
         if (!msg_valid || msg_pin !== 5'd6 || msg_data !== 32'h8006) stable = 1'b0;
         @(negedge clk);
      end
      check("R11 stalled message held", 64'(stable), 64'd1);
      msg_ready = 1'b1;
      wait_msg(3, g, a, d, p);
      check("R10 first after pointer", 64'(p), 64'd6);
      wait_msg(3, g, a, d, p);
      check("R10 next ascending", 64'(p), 64'd12);
      wait_msg(3, g, a, d, p);
      check("R10 wrap to low pin", 64'(p), 64'd3);
      pulse_req(5'd3, 1'b0); pulse_req(5'd6, 1'b0); pulse_req(5'd12, 1'b0);
      rirr_clr[3] = 1'b1; rirr_clr[6] = 1'b1; rirr_clr[12] = 1'b1;
      @(negedge clk);
      rirr_clr = '0;
      ent[3][16] = 1'b1; ent[6][16] = 1'b1; ent[12][16] = 1'b1;
   endtask

   task automatic t_same_cycle();
      int cnt;
      ent[20] = mk(8'h20, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0);
      pulse_req(5'd20, 1'b1);
      pulse_req(5'd20, 1'b1);
      count_msgs(6, cnt);
      check("R6 request during service kept", 64'(cnt), 64'd2);
      ent[20][16] = 1'b1;
   endtask

   task automatic t_level_low();
      int cnt;
      ent[14] = mk(8'h14, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0);
      pulse_req(5'd14, 1'b1);
      pulse_req(5'd14, 1'b0);
      ent[14][16] = 1'b0;
      count_msgs(6, cnt);
      check("R3 pending withdrawn by low level", 64'(cnt), 64'd0);
      ent[14][16] = 1'b1;
   endtask

   task automatic t_edge_flag();
      bit g; logic [31:0] a, d; logic [4:0] p;
      ent[13] = mk(8'h1D, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0);
      pulse_req(5'd13, 1'b1);
      wait_msg(6, g, a, d, p);
      check("R7 flag set before mode change", 64'(rirr_q[13]), 64'd1);
      ent[13] = mk(8'h1D, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      @(negedge clk);
      check("R12 edge mode clears flag", 64'(rirr_q[13]), 64'd0);
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_level = 1'b0;
      legacy_vec = '0; rirr_clr = '0; msg_ready = 1'b1;
      for (int i = 0; i < NP; i++) ent[i] = mk(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge_basic();
      t_remap();
      t_out_of_range();
      t_masked_edge();
      t_level();
      t_masked_level();
      t_legacy();
      t_order_stall();
      t_same_cycle();
      t_level_low();
      t_edge_flag();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule